// File: doc/BRIEF.md
# CAN Transmit Mailbox Scheduler

This block sits between software and the bit-level engine of a CAN controller and decides which of fifteen transmit mailboxes goes out next. Software stores an 11-bit identifier in each mailbox and then marks the mailbox pending. The scheduler runs an internal arbitration among the pending mailboxes. It copies the winner's number and identifier into a single transmit buffer and offers that buffer to the bit engine.

The engine takes the buffer with a start strobe. It later reports either an error-free completion or a lost bus arbitration. A completion retires the mailbox and raises its acknowledge flag. A lost arbitration leaves the mailbox pending, and the scheduler arbitrates again. Software can withdraw a pending request through a cancel register, which raises an abort flag. Cancellation is refused during the internal arbitration cycle. It is also refused for the buffered mailbox once the engine has taken it. The acknowledge and abort flags are gated by a per-mailbox mask and a global enable, and together they drive one mailbox-empty interrupt.

Two priority policies can be selected. In mailbox-order mode the lowest-numbered mailbox wins. In identifier mode the lowest identifier wins.

Top module: `can_tx_sched`

## Requirements
- R1: Writing the pending register (address 0) sets the pending bit of every mailbox whose data bit is 1 (data bit i-1 belongs to mailbox i). Data bits that are 0 leave their pending bits unchanged, so writing 0 never withdraws a request.
- R2: With control bit 0 (address 5) at 0, arbitration picks the lowest-numbered pending mailbox.
- R3: With control bit 0 at 1, arbitration picks the pending mailbox with the numerically lowest identifier, and a tie goes to the lower mailbox number. The identifier of mailbox i is written and read at address 15+i, in bits 10:0.
- R4: A request found while idle is arbitrated in the next cycle, and the buffer is offered (tx_valid high, with tx_mbox and tx_id) in the cycle after that. A pending-register write with nonzero data while the buffer is offered and not yet started starts a new arbitration.
- R5: A tx_done pulse while the engine holds the buffer clears that mailbox's pending bit and sets its acknowledge flag (address 2).
- R6: A tx_lost pulse keeps the mailbox pending, and the scheduler arbitrates again before offering the buffer anew.
- R7: Writing 1 to a cancel bit (address 1) for a pending mailbox that is not locked clears its pending bit and sets its abort flag (address 3). A buffered mailbox that has not been started can be cancelled, and arbitration then reruns.
- R8: A cancel has no effect on pending bits or flags when it arrives during the arbitration cycle, when it targets the buffered mailbox while the engine holds it or in the cycle the engine starts it, or when it targets a mailbox that is not pending.
- R9: Writing 1 to a bit of the acknowledge or abort register clears that flag. A completion or cancel that sets the same flag in the same cycle takes precedence over the clear.
- R10: irq is high exactly when control bit 1 is 1 and some mailbox has its mask bit (address 4) set together with its acknowledge or abort flag.
- R11: After reset, all pending bits, flags, masks, control bits and identifiers are 0, tx_valid is low and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| tx_valid | output | 1 | Transmit buffer offered to the engine |
| tx_mbox | output | 4 | Mailbox number (1 to 15) held in the buffer |
| tx_id | output | 11 | Identifier held in the buffer |
| tx_start | input | 1 | Engine takes the offered buffer |
| tx_done | input | 1 | Engine reports error-free completion |
| tx_lost | input | 1 | Engine reports lost bus arbitration |
| irq | output | 1 | Mailbox-empty interrupt |

## Verification
Mailbox-order mode is driven with identifiers that fall as the mailbox number rises. With those identifiers the two modes always pick different winners, so a mode mix-up shows at once. Identifier mode is driven with a tie between two mailboxes and with a lower identifier that arrives while the buffer is offered, which separates the tie rule from re-arbitration on a new request. Cancels are aimed at the buffered mailbox before and after start, at another mailbox while the engine is busy, at a mailbox during the arbitration cycle and at a mailbox that is not pending, which tells each lock window apart from a correct abort. The interrupt is stepped through mask, global enable and flag clears one at a time.

// File: rtl/can_tx_pkg.sv
package can_tx_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARB    = 2'd1,
        ST_LOADED = 2'd2,
        ST_ACTIVE = 2'd3
    } sched_state_e;

    localparam int REG_PEND    = 0;
    localparam int REG_CANCEL  = 1;
    localparam int REG_ACK     = 2;
    localparam int REG_ABORT   = 3;
    localparam int REG_MASK    = 4;
    localparam int REG_CTRL    = 5;
    localparam int REG_ID_BASE = 16;
endpackage

// File: rtl/can_tx_idbank.sv
module can_tx_idbank #(
    parameter int N_MBOX = 15,
    parameter int ID_W   = 11,
    localparam int IDX_W = $clog2(N_MBOX)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [ID_W-1:0]                wr_val,
    output logic [N_MBOX-1:0][ID_W-1:0]    ids
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [N_MBOX-1:0][ID_W-1:0] ids_d, ids_q;

    always_comb begin
        ids_d = ids_q;
        if (wr_en) begin
            ids_d[wr_idx] = wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ids_q <= '0;
        end else begin
            ids_q <= ids_d;
        end
    end

    assign ids = ids_q;
endmodule

// File: rtl/can_tx_pick.sv
module can_tx_pick #(
    parameter int N_MBOX = 15,
    parameter int ID_W   = 11,
    localparam int IDX_W = $clog2(N_MBOX)
) (
    input  logic [N_MBOX-1:0]              pend,
    input  logic [N_MBOX-1:0][ID_W-1:0]    ids,
    input  logic                           by_id,
    output logic                           any,
    output logic [IDX_W-1:0]               win_idx
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [ID_W-1:0] best_id;

    // Scan upward: the first pending mailbox is taken, and a later one
    // replaces it only with a strictly lower identifier in identifier mode,
    // so ties stay with the lower mailbox number.
    always_comb begin
        any     = 1'b0;
        win_idx = '0;
        best_id = '1;
        for (int k = 0; k < N_MBOX; k++) begin
            if (pend[k] && (!any || (by_id && (ids[k] < best_id)))) begin
                any     = 1'b1;
                win_idx = IDX_W'(k);
                best_id = ids[k];
            end
        end
    end
endmodule

// File: rtl/can_tx_flags.sv
module can_tx_flags #(
    parameter int N_MBOX = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_MBOX-1:0] set_ack,
    input  logic [N_MBOX-1:0] set_abort,
    input  logic [N_MBOX-1:0] clr_ack,
    input  logic [N_MBOX-1:0] clr_abort,
    input  logic              mask_we,
    input  logic [N_MBOX-1:0] mask_val,
    input  logic              irq_en,
    output logic [N_MBOX-1:0] ack,
    output logic [N_MBOX-1:0] abort,
    output logic [N_MBOX-1:0] mask,
    output logic              irq
);
    timeunit 1ns;
    timeprecision 1ps;

    typedef struct packed {
        logic [N_MBOX-1:0] ack;
        logic [N_MBOX-1:0] abort;
        logic [N_MBOX-1:0] mask;
    } flag_t;

    flag_t d, q;

    always_comb begin
        d       = q;
        d.ack   = (q.ack & ~clr_ack) | set_ack;
        d.abort = (q.abort & ~clr_abort) | set_abort;
        if (mask_we) begin
            d.mask = mask_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ack   = q.ack;
    assign abort = q.abort;
    assign mask  = q.mask;
    assign irq   = irq_en & (|((q.ack | q.abort) & q.mask));

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ((|clr_ack) && !(|set_ack)) |=> ((q.ack & $past(clr_ack)) == '0))
        else $error("acknowledge clear ignored"); // R9

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_abort) |=> ((q.abort & $past(set_abort)) == $past(set_abort)))
        else $error("abort flag not set"); // R9

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|q.mask))
        else $error("interrupt without any mask bit"); // R10
endmodule

// File: rtl/can_tx_sched.sv
module can_tx_sched
    import can_tx_pkg::*;
#(
    parameter int N_MBOX = 15,
    parameter int ID_W   = 11,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 5,
    localparam int IDX_W = $clog2(N_MBOX),
    localparam int MB_W  = $clog2(N_MBOX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              tx_valid,
    output logic [MB_W-1:0]   tx_mbox,
    output logic [ID_W-1:0]   tx_id,
    input  logic              tx_start,
    input  logic              tx_done,
    input  logic              tx_lost,
    output logic              irq
);
    timeunit 1ns;
    timeprecision 1ps;

    typedef struct packed {
        sched_state_e      st;
        logic [N_MBOX-1:0] pend;
        logic [IDX_W-1:0]  bidx;
        logic [ID_W-1:0]   bid;
        logic              by_id;
        logic              irq_en;
    } core_t;

    core_t d, q;

    logic [N_MBOX-1:0]           set_bits, cancel_bits, cancel_eff, done_hit;
    logic [N_MBOX-1:0]           buf_oh, lower_mask, allow;
    logic [N_MBOX-1:0]           clr_ack, clr_abort;
    logic [N_MBOX-1:0]           ack_v, abort_v, mask_v;
    logic [N_MBOX-1:0][ID_W-1:0] ids;
    logic                        set_req, lock_buf, pick_any;
    logic [IDX_W-1:0]            pick_idx;
    logic                        id_we, mask_we;
    logic [IDX_W-1:0]            id_idx, rd_idx;

    // ---------------- write decode ----------------
    always_comb begin
        set_bits    = '0;
        cancel_bits = '0;
        clr_ack     = '0;
        clr_abort   = '0;
        mask_we     = 1'b0;
        id_we       = 1'b0;
        id_idx      = IDX_W'(wr_addr - ADDR_W'(REG_ID_BASE));
        if (wr_en) begin
            if (wr_addr == ADDR_W'(REG_PEND))   set_bits    = wr_data[N_MBOX-1:0];
            if (wr_addr == ADDR_W'(REG_CANCEL)) cancel_bits = wr_data[N_MBOX-1:0];
            if (wr_addr == ADDR_W'(REG_ACK))    clr_ack     = wr_data[N_MBOX-1:0];
            if (wr_addr == ADDR_W'(REG_ABORT))  clr_abort   = wr_data[N_MBOX-1:0];
            if (wr_addr == ADDR_W'(REG_MASK))   mask_we     = 1'b1;
            if ((wr_addr >= ADDR_W'(REG_ID_BASE)) &&
                (wr_addr <  ADDR_W'(REG_ID_BASE + N_MBOX))) id_we = 1'b1;
        end
    end

    assign set_req    = |set_bits;
    assign buf_oh     = N_MBOX'(1) << q.bidx;
    assign lower_mask = (N_MBOX'(1) << pick_idx) - N_MBOX'(1);

    // ---------------- submodules ----------------
    can_tx_idbank #(.N_MBOX(N_MBOX), .ID_W(ID_W)) u_ids (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (id_we),
        .wr_idx (id_idx),
        .wr_val (wr_data[ID_W-1:0]),
        .ids    (ids)
    );

    can_tx_pick #(.N_MBOX(N_MBOX), .ID_W(ID_W)) u_pick (
        .pend    (q.pend),
        .ids     (ids),
        .by_id   (q.by_id),
        .any     (pick_any),
        .win_idx (pick_idx)
    );

    can_tx_flags #(.N_MBOX(N_MBOX)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_ack   (done_hit),
        .set_abort (cancel_eff),
        .clr_ack   (clr_ack),
        .clr_abort (clr_abort),
        .mask_we   (mask_we),
        .mask_val  (wr_data[N_MBOX-1:0]),
        .irq_en    (q.irq_en),
        .ack       (ack_v),
        .abort     (abort_v),
        .mask      (mask_v),
        .irq       (irq)
    );

    // ---------------- next state ----------------
    always_comb begin
        d = q;

        // The buffered mailbox is locked from the start strobe until the
        // engine reports; the arbitration cycle locks every mailbox.
        lock_buf = (q.st == ST_ACTIVE) || ((q.st == ST_LOADED) && tx_start);
        if (q.st == ST_ARB) begin
            allow = '0;
        end else if (lock_buf) begin
            allow = ~buf_oh;
        end else begin
            allow = '1;
        end
        cancel_eff = cancel_bits & q.pend & allow;
        done_hit   = ((q.st == ST_ACTIVE) && tx_done) ? buf_oh : '0;
        d.pend     = (q.pend & ~(cancel_eff | done_hit)) | set_bits;

        if (wr_en && (wr_addr == ADDR_W'(REG_CTRL))) begin
            d.by_id  = wr_data[0];
            d.irq_en = wr_data[1];
        end

        unique case (q.st)
            ST_IDLE: begin
                if (|d.pend) d.st = ST_ARB;
            end
            ST_ARB: begin
                d.bidx = pick_idx;
                d.bid  = ids[pick_idx];
                if (set_req) begin
                    d.st = ST_ARB;
                end else if (pick_any) begin
                    d.st = ST_LOADED;
                end else begin
                    d.st = ST_IDLE;
                end
            end
            ST_LOADED: begin
                if (tx_start) begin
                    d.st = ST_ACTIVE;
                end else if (set_req || (|(cancel_eff & buf_oh))) begin
                    d.st = ST_ARB;
                end
            end
            ST_ACTIVE: begin
                if (tx_done) begin
                    d.st = ST_IDLE;
                end else if (tx_lost) begin
                    d.st = ST_ARB;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // ---------------- outputs and read mux ----------------
    assign tx_valid = (q.st == ST_LOADED);
    assign tx_mbox  = MB_W'(q.bidx) + MB_W'(1);
    assign tx_id    = q.bid;
    assign rd_idx   = IDX_W'(rd_addr - ADDR_W'(REG_ID_BASE));

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(REG_PEND)) begin
            rd_data = DATA_W'(q.pend);
        end else if (rd_addr == ADDR_W'(REG_ACK)) begin
            rd_data = DATA_W'(ack_v);
        end else if (rd_addr == ADDR_W'(REG_ABORT)) begin
            rd_data = DATA_W'(abort_v);
        end else if (rd_addr == ADDR_W'(REG_MASK)) begin
            rd_data = DATA_W'(mask_v);
        end else if (rd_addr == ADDR_W'(REG_CTRL)) begin
            rd_data = DATA_W'({q.irq_en, q.by_id});
        end else if ((rd_addr >= ADDR_W'(REG_ID_BASE)) &&
                     (rd_addr <  ADDR_W'(REG_ID_BASE + N_MBOX))) begin
            rd_data = DATA_W'(ids[rd_idx]);
        end
    end

    // ---------------- assertions ----------------
    AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == ADDR_W'(REG_PEND)))
        |=> ((q.pend & $past(q.pend & ~done_hit)) == $past(q.pend & ~done_hit)))
        else $error("pending bit lost on pending write"); // R1

    AST_ORDER_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_ARB) && !q.by_id && pick_any) |-> ((q.pend & lower_mask) == '0))
        else $error("lower pending mailbox skipped"); // R2

    AST_VALID_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (|(q.pend & buf_oh)))
        else $error("offered mailbox not pending"); // R4

    AST_DONE_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_ACTIVE) && tx_done && !set_req)
        |=> (!(|(q.pend & $past(buf_oh))) && (|(ack_v & $past(buf_oh)))))
        else $error("completion not retired"); // R5

    AST_LOST_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_ACTIVE) && tx_lost && !tx_done)
        |=> ((q.st == ST_ARB) && (|(q.pend & $past(buf_oh)))))
        else $error("lost arbitration dropped request"); // R6

    AST_ARB_NO_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_ARB) && !(wr_en && (wr_addr == ADDR_W'(REG_ABORT))))
        |=> (abort_v == $past(abort_v)))
        else $error("cancel accepted during arbitration"); // R8
endmodule

// File: tb/sim_can_tx_sched.sv
module sim_can_tx_sched;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        tx_valid;
    logic [3:0]  tx_mbox;
    logic [10:0] tx_id;
    logic        tx_start = 1'b0;
    logic        tx_done = 1'b0;
    logic        tx_lost = 1'b0;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit hold = 1'b0;
    logic [4:0] peek_a = '0;
    int rd_k = 0;

    always #2.5 clk = ~clk;  // 200 MHz

    can_tx_sched u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tx_valid(tx_valid), .tx_mbox(tx_mbox), .tx_id(tx_id),
        .tx_start(tx_start), .tx_done(tx_done), .tx_lost(tx_lost), .irq(irq)
    );

    // ---------------- behavioural reference ----------------
    int        m_st;      // 0 idle, 1 arbitrating, 2 offered, 3 engine busy
    bit [14:0] m_pend, m_ack, m_abort, m_mask;
    bit        m_mode, m_gen;
    int        m_bidx, m_bid;
    int        m_ids[15];

    function automatic int mread(input int a);
        if (a == 0) return int'(m_pend);
        if (a == 2) return int'(m_ack);
        if (a == 3) return int'(m_abort);
        if (a == 4) return int'(m_mask);
        if (a == 5) return int'({m_gen, m_mode});
        if (a >= 16 && a <= 30) return m_ids[a-16];
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_pend = 0; m_ack = 0; m_abort = 0; m_mask = 0;
            m_mode = 0; m_gen = 0; m_bidx = 0; m_bid = 0;
            foreach (m_ids[k]) m_ids[k] = 0;
        end else begin
            bit [14:0] setb, canb, boh, allow, eff, doneb, np;
            int win, best, nst;
            bit found;
            setb  = (wr_en && wr_addr == 0) ? wr_data[14:0] : 15'd0;
            canb  = (wr_en && wr_addr == 1) ? wr_data[14:0] : 15'd0;
            boh   = 15'd1 << m_bidx;
            if (m_st == 1) allow = 15'd0;
            else if (m_st == 3 || (m_st == 2 && tx_start)) allow = ~boh;
            else allow = 15'h7fff;
            eff   = canb & m_pend & allow;
            doneb = (m_st == 3 && tx_done) ? boh : 15'd0;
            np    = (m_pend & ~(eff | doneb)) | setb;
            found = 0; win = 0; best = 0;
            for (int k = 0; k < 15; k++) begin
                if (m_pend[k] && (!found || (m_mode && m_ids[k] < best))) begin
                    found = 1; win = k; best = m_ids[k];
                end
            end
            nst = m_st;
            case (m_st)
                0: if (np != 0) nst = 1;
                1: begin
                    m_bidx = win; m_bid = m_ids[win];
                    nst = (setb != 0) ? 1 : (found ? 2 : 0);
                end
                2: if (tx_start) nst = 3;
                   else if (setb != 0 || (eff & boh) != 0) nst = 1;
                3: if (tx_done) nst = 0; else if (tx_lost) nst = 1;
                default: nst = 0;
            endcase
            m_st = nst;
            m_pend = np;
            m_ack = (m_ack & ~((wr_en && wr_addr == 2) ? wr_data[14:0] : 15'd0)) | doneb;
            m_abort = (m_abort & ~((wr_en && wr_addr == 3) ? wr_data[14:0] : 15'd0)) | eff;
            if (wr_en && wr_addr == 4) m_mask = wr_data[14:0];
            if (wr_en && wr_addr == 5) begin m_mode = wr_data[0]; m_gen = wr_data[1]; end
            if (wr_en && wr_addr >= 16 && wr_addr <= 30) m_ids[wr_addr-16] = int'(wr_data[10:0]);
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        rd_addr <= hold ? peek_a : ((rd_k % 20) < 5 ? 5'(int'(((rd_k % 20) == 0) ? 0 : (rd_k % 20) + 1))
                                                 : 5'(16 + (rd_k % 20) - 5));
        rd_k <= rd_k + 1;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(tx_valid == (m_st == 2), "R4 tx_valid per cycle", int'(tx_valid), int'(m_st == 2));
            if (m_st == 2) begin
                chk(int'(tx_mbox) == m_bidx + 1, "R2 tx_mbox per cycle", int'(tx_mbox), m_bidx + 1);
                chk(int'(tx_id) == m_bid, "R3 tx_id per cycle", int'(tx_id), m_bid);
            end
            chk(irq == (m_gen && ((m_ack | m_abort) & m_mask) != 0), "R10 irq per cycle",
                int'(irq), int'(m_gen && ((m_ack | m_abort) & m_mask) != 0));
            chk(int'(rd_data) == mread(int'(rd_addr)), "R1 readback per cycle",
                int'(rd_data), mread(int'(rd_addr)));
        end
    end

    // ---------------- stimulus ----------------
    task automatic clear_strobes();
        wr_en = 0; tx_start = 0; tx_done = 0; tx_lost = 0;
    endtask

    task automatic tick();
        @(negedge clk); clear_strobes();
    endtask

    task automatic wr(input int a, input int v);
        @(negedge clk); clear_strobes();
        wr_en = 1; wr_addr = 5'(a); wr_data = 16'(v);
    endtask

    task automatic start();
        @(negedge clk); clear_strobes(); tx_start = 1;
    endtask

    task automatic done();
        @(negedge clk); clear_strobes(); tx_done = 1;
    endtask

    task automatic lost();
        @(negedge clk); clear_strobes(); tx_lost = 1;
    endtask

    task automatic peek(input int a, input int exp, input string tag);
        @(negedge clk); clear_strobes(); hold = 1; peek_a = 5'(a);
        @(negedge clk);
        chk(int'(rd_data) == exp, tag, int'(rd_data), exp);
        hold = 0;
    endtask

    task automatic wait_valid(input int exp, input string tag);
        int n;
        n = 0;
        do begin
            tick();
            n++;
        end while (!tx_valid && n < 50);
        chk(tx_valid && int'(tx_mbox) == exp, tag, tx_valid ? int'(tx_mbox) : 0, exp);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        tick();
        chk(tx_valid == 0, "R11 tx_valid after reset", int'(tx_valid), 0);
        chk(irq == 0, "R11 irq after reset", int'(irq), 0);
        peek(0, 0, "R11 pending after reset");
        peek(5, 0, "R11 control after reset");

        // R1: a zero write requests nothing
        wr(0, 0); tick(); tick();
        peek(0, 0, "R1 zero write sets nothing");
        chk(tx_valid == 0, "R1 no offer after zero write", int'(tx_valid), 0);

        // Mailbox-order mode; identifiers fall as mailbox number rises
        for (int k = 1; k <= 15; k++) wr(15 + k, 'h7ff - k);
        wr(0, 'h114);                       // mailboxes 3, 5, 9
        wait_valid(3, "R2 lowest mailbox wins");
        start(); done(); tick();
        peek(2, 'h004, "R5 acknowledge after completion");
        peek(0, 'h110, "R5 pending cleared after completion");
        wait_valid(5, "R2 next mailbox");
        start(); lost();
        wait_valid(5, "R6 lost keeps mailbox offered again");
        peek(0, 'h110, "R6 pending kept after loss");
        start(); done();
        wait_valid(9, "R2 last mailbox");
        wr(0, 0); tick();
        peek(0, 'h100, "R1 zero write keeps pending");
        start(); done(); tick(); tick();
        peek(2, 'h114, "R5 acknowledges accumulate");
        wr(2, 'h014); tick();
        peek(2, 'h100, "R9 write-one clears acknowledge");
        wr(2, 'h100);

        // Identifier mode
        wr(5, 1);
        wr(17, 'h300); wr(19, 'h100); wr(22, 'h100); wr(25, 'h050);
        wr(0, 'h04a);                       // mailboxes 2, 4, 7
        wait_valid(4, "R3 lowest identifier wins");
        chk(int'(tx_id) == 'h100, "R3 identifier in buffer", int'(tx_id), 'h100);
        wr(0, 'h200);                       // mailbox 10 joins while offered
        wait_valid(10, "R4 new request re-arbitrates");
        start(); done();
        wait_valid(4, "R3 tie goes to lower mailbox");
        start(); done();
        wait_valid(7, "R3 tied mailbox next");
        start(); done();
        wait_valid(2, "R3 highest identifier last");
        start(); done(); tick(); tick();
        wr(2, 'h7fff);

        // Cancellation, mailbox-order mode
        wr(5, 0);
        wr(0, 'h021);                       // mailboxes 1, 6
        wait_valid(1, "R7 setup");
        wr(1, 'h001);                       // offered, not started
        tick();
        peek(3, 'h001, "R7 abort flag on cancel");
        wait_valid(6, "R7 cancel re-arbitrates");
        start();
        wr(1, 'h020);                       // engine holds mailbox 6
        tick();
        peek(3, 'h001, "R8 cancel of busy mailbox refused");
        peek(0, 'h020, "R8 busy mailbox stays pending");
        done(); tick(); tick();
        wr(0, 'h800);                       // mailbox 12
        wr(1, 'h800);                       // arrives in arbitration cycle
        wait_valid(12, "R8 cancel during arbitration refused");
        peek(3, 'h001, "R8 no abort during arbitration");
        wr(0, 'h1000);                      // mailbox 13
        wait_valid(12, "R4 re-arbitration keeps winner");
        start();
        wr(1, 'h1000);                      // other mailbox while busy
        tick();
        peek(3, 'h1001, "R7 cancel of other mailbox while busy");
        done(); tick(); tick();
        peek(0, 0, "R7 nothing left pending");
        wr(1, 'h4000);
        tick();
        peek(3, 'h1001, "R8 cancel of idle mailbox ignored");

        // Interrupt gating; acknowledge holds 0x820, abort 0x1001
        tick();
        chk(irq == 0, "R10 irq off without mask", int'(irq), 0);
        wr(4, 'h0020); tick();
        chk(irq == 0, "R10 irq off without global enable", int'(irq), 0);
        wr(5, 2); tick();
        chk(irq == 1, "R10 irq on with mask and enable", int'(irq), 1);
        wr(2, 'h0020); tick();
        chk(irq == 0, "R10 irq off after acknowledge clear", int'(irq), 0);
        wr(4, 'h1000); tick();
        chk(irq == 1, "R10 irq on from abort flag", int'(irq), 1);
        wr(3, 'h1001); tick();
        chk(irq == 0, "R10 irq off after abort clear", int'(irq), 0);
        peek(3, 0, "R9 write-one clears abort");

        repeat (4) tick();
        summary();
        $finish;
    end
endmodule